// File: doc/BRIEF.md
# CAN Bit Timer

This block is the bit-timing stage of a CAN receiver and transmitter. A 6-bit prescaler divides the system clock into time quanta. Each bit is built from those quanta in three parts: one synchronization quantum, a first timing segment that covers propagation delay and early phase error, and a second timing segment that ends the bit. The receive line first passes through a two-flop synchronizer. It is sampled once per bit, at the boundary between the two timing segments. A transmit strobe marks the start of every bit, which is the point where the bit stream logic may drive a new value onto the line.

Bus timing keeps aligned with the other nodes by watching for recessive-to-dominant transitions. While the bus is idle, such a transition starts a new frame, so the bit timer restarts at once (hard synchronization). During a frame, an edge that arrives late or early stretches the first segment or cuts the second, by no more than the programmed jump width. No such correction is made while this node is driving a dominant bit, and a bit gets at most one correction. The time quantum length, the two segment lengths and the jump width are set to suit the baud rate and the delays of the physical layer.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted and until the first strobe after it, `sample_stb` and `tx_stb` are 0 and `rx_bit` is 1.
- R2: One time quantum lasts `cfg_brp`+1 clocks. The first segment lasts `cfg_tseg1`+1 quanta and the second lasts `cfg_tseg2`+1 quanta. With no edges on the line, `tx_stb` gives one-cycle pulses spaced (`cfg_brp`+1)·(`cfg_tseg1`+`cfg_tseg2`+3) clocks apart.
- R3: Each bit has exactly one one-cycle `sample_stb`, which comes (`cfg_brp`+1)·(`cfg_tseg1`+2) clocks after that bit's `tx_stb`. On that strobe `rx_bit` takes the synchronized line level (0 = dominant) and holds it until the next strobe.
- R4: With `bus_idle`=1, a falling edge restarts the bit. `tx_stb` pulses three rising clock edges after `rx_raw` is first captured low, and the new bit then follows nominal timing, with its sample point (`cfg_brp`+1)·(`cfg_tseg1`+2) clocks after that pulse.
- R5: An edge is placed in the clock cycle in which the twice-registered line first reads low, and quantum index q counts from 0 at the synchronization quantum. With `bus_idle`=0 and `tx_bit`=1, an edge with 1 ≤ q ≤ `cfg_tseg1`+1 lengthens the first segment by min(q, `cfg_sjw`+1) quanta.
- R6: Under the same conditions, an edge in quantum c (counted from 0) of the second segment, whose length is L2, makes that segment last max(L2−`cfg_sjw`−1, c+1) quanta.
- R7: While `tx_bit`=0 (dominant), an edge causes no resynchronization. Bit length and sample point stay nominal.
- R8: An edge inside the synchronization quantum causes no adjustment.
- R9: Only the first qualifying edge in a bit is acted on. A bit that was started by hard synchronization takes no resynchronization.
- R10: `sample_stb` and `tx_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_raw | input | 1 | Unsynchronized receive line, 0 = dominant |
| tx_bit | input | 1 | Bit this node is currently driving, 0 = dominant |
| bus_idle | input | 1 | High between frames; selects hard synchronization |
| cfg_brp | input | 6 | Prescaler; quantum = value+1 clocks |
| cfg_tseg1 | input | 4 | First timing segment length minus one, in quanta |
| cfg_tseg2 | input | 3 | Second timing segment length minus one, in quanta |
| cfg_sjw | input | 2 | Jump width minus one, in quanta |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| rx_bit | output | 1 | Bit value taken at the last sample point |
| tx_stb | output | 1 | One-cycle pulse at the start of each bit |

## Verification
The assertions assume the configuration stays constant for the whole of a bit. They also assume that `bus_idle` is steady in the cycles around a detected edge, so that each edge is clearly either a hard synchronization or a resynchronization. The stimulus changes the configuration only between bits and then lets two whole bits pass before it measures anything. It switches `bus_idle` and `tx_bit` only right after a bit-start strobe, and it makes each line edge a short low pulse placed at a known cycle of the bit. With these limits, the position of every edge is known to the quantum, and so is the expected correction.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_ONE  = 2'd1,
      SEG_TWO  = 2'd2
   } bt_seg_e;
endpackage

// File: rtl/bt_line_sync.sv
module bt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_s,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= line_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign line_s = chain[STAGES-1];
   assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/bt_quantum_gen.sv
module bt_quantum_gen #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRP_W-1:0] brp,
   input  logic             restart,
   output logic             tq_stb
);
   logic [BRP_W-1:0] cnt;

   assign tq_stb = (cnt >= brp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tq_stb)  cnt <= '0;
      else              cnt <= cnt + BRP_W'(1);
   end
endmodule

// File: rtl/bt_segment_ctl.sv
module bt_segment_ctl
   import can_bt_pkg::*;
#(
   parameter int TSEG1_W = 4,
   parameter int TSEG2_W = 3,
   parameter int SJW_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tq_stb,
   input  logic               fall,
   input  logic               line_s,
   input  logic               bus_idle,
   input  logic               tx_bit,
   input  logic [TSEG1_W-1:0] tseg1,
   input  logic [TSEG2_W-1:0] tseg2,
   input  logic [SJW_W-1:0]   sjw,
   output logic               hard_sync,
   output logic               sample_stb,
   output logic               rx_bit,
   output logic               tx_stb
);
   localparam int SEG_MAX = (1 << TSEG1_W) + (1 << SJW_W);
   localparam int SEG_W   = $clog2(SEG_MAX + 1);
   localparam logic [SEG_W-1:0] ONE_Q = SEG_W'(1);

   bt_seg_e          seg;
   logic [SEG_W-1:0] seg_cnt, seg_len;
   logic             resynced;
   logic             resync, seg_end;
   logic [SEG_W-1:0] sjw_q, cnt_nxt, grow, cut, len_adj, len_now;

   always_comb begin
      hard_sync = bus_idle & fall;
      resync    = ~bus_idle & fall & tx_bit & ~resynced & (seg != SEG_SYNC);
      sjw_q     = SEG_W'(sjw) + ONE_Q;
      cnt_nxt   = seg_cnt + ONE_Q;
      grow      = (cnt_nxt < sjw_q) ? cnt_nxt : sjw_q;
      cut       = (seg_len > sjw_q) ? (seg_len - sjw_q) : '0;
      if (seg == SEG_TWO) len_adj = (cut > seg_cnt) ? cut : cnt_nxt;
      else                len_adj = seg_len + grow;
      len_now   = resync ? len_adj : seg_len;
      seg_end   = tq_stb & (cnt_nxt == len_now);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg        <= SEG_SYNC;
         seg_cnt    <= '0;
         seg_len    <= ONE_Q;
         resynced   <= 1'b0;
         sample_stb <= 1'b0;
         tx_stb     <= 1'b0;
         rx_bit     <= 1'b1;
      end else begin
         sample_stb <= 1'b0;
         tx_stb     <= 1'b0;
         if (hard_sync) begin
            seg      <= SEG_SYNC;
            seg_cnt  <= '0;
            seg_len  <= ONE_Q;
            resynced <= 1'b1;
            tx_stb   <= 1'b1;
         end else begin
            if (resync) begin
               resynced <= 1'b1;
               seg_len  <= len_adj;
            end
            if (seg_end) begin
               seg_cnt <= '0;
               case (seg)
                  SEG_SYNC: begin
                     seg     <= SEG_ONE;
                     seg_len <= SEG_W'(tseg1) + ONE_Q;
                  end
                  SEG_ONE: begin
                     seg        <= SEG_TWO;
                     seg_len    <= SEG_W'(tseg2) + ONE_Q;
                     sample_stb <= 1'b1;
                     rx_bit     <= line_s;
                  end
                  default: begin
                     seg      <= SEG_SYNC;
                     seg_len  <= ONE_Q;
                     resynced <= 1'b0;
                     tx_stb   <= 1'b1;
                  end
               endcase
            end else if (tq_stb) begin
               seg_cnt <= cnt_nxt;
            end
         end
      end
   end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int BRP_W       = 6,
   parameter int TSEG1_W     = 4,
   parameter int TSEG2_W     = 3,
   parameter int SJW_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_raw,
   input  logic               tx_bit,
   input  logic               bus_idle,
   input  logic [BRP_W-1:0]   cfg_brp,
   input  logic [TSEG1_W-1:0] cfg_tseg1,
   input  logic [TSEG2_W-1:0] cfg_tseg2,
   input  logic [SJW_W-1:0]   cfg_sjw,
   output logic               sample_stb,
   output logic               rx_bit,
   output logic               tx_stb
);
   if (BRP_W < 1 || BRP_W > 10) begin : g_bad_brp
      $error("BRP_W out of range");
   end
   if (TSEG1_W < 1 || TSEG1_W > 6) begin : g_bad_t1
      $error("TSEG1_W out of range");
   end
   if (TSEG2_W < 1 || TSEG2_W > 5) begin : g_bad_t2
      $error("TSEG2_W out of range");
   end
   if (SJW_W < 1 || SJW_W > TSEG2_W) begin : g_bad_sjw
      $error("SJW_W out of range");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES out of range");
   end

   logic line_s, line_fall, tq_stb, hard_sync;

   bt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (rx_raw),
      .line_s  (line_s),
      .fall    (line_fall)
   );

   bt_quantum_gen #(.BRP_W(BRP_W)) u_tq (
      .clk     (clk),
      .rst_n   (rst_n),
      .brp     (cfg_brp),
      .restart (hard_sync),
      .tq_stb  (tq_stb)
   );

   bt_segment_ctl #(
      .TSEG1_W (TSEG1_W),
      .TSEG2_W (TSEG2_W),
      .SJW_W   (SJW_W)
   ) u_seg (
      .clk        (clk),
      .rst_n      (rst_n),
      .tq_stb     (tq_stb),
      .fall       (line_fall),
      .line_s     (line_s),
      .bus_idle   (bus_idle),
      .tx_bit     (tx_bit),
      .tseg1      (cfg_tseg1),
      .tseg2      (cfg_tseg2),
      .sjw        (cfg_sjw),
      .hard_sync  (hard_sync),
      .sample_stb (sample_stb),
      .rx_bit     (rx_bit),
      .tx_stb     (tx_stb)
   );
endmodule

// File: rtl/bt_checker.sv
module bt_checker (
   input logic clk,
   input logic rst_n,
   input logic bus_idle,
   input logic fall,
   input logic tx_stb,
   input logic sample_stb,
   input logic rx_bit
);
   logic sampled_this_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sampled_this_bit <= 1'b0;
      else if (tx_stb)     sampled_this_bit <= 1'b0;
      else if (sample_stb) sampled_this_bit <= 1'b1;
   end

   a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && tx_stb));

   a_r3_one_sample_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !sampled_this_bit);

   a_r3_rx_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |-> $stable(rx_bit));

   a_r4_hard_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idle && fall) |=> tx_stb);
endmodule

bind can_bit_timer bt_checker u_bt_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_idle   (bus_idle),
   .fall       (line_fall),
   .tx_stb     (tx_stb),
   .sample_stb (sample_stb),
   .rx_bit     (rx_bit)
);

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
   logic       clk = 1'b0;
   logic       rst_n, rx_raw, tx_bit, bus_idle;
   logic [5:0] cfg_brp;
   logic [3:0] cfg_tseg1;
   logic [2:0] cfg_tseg2;
   logic [1:0] cfg_sjw;
   logic       sample_stb, rx_bit, tx_stb;

   int cyc = 0, n_chk = 0, n_bad = 0, last_samp = -1, overlaps = 0;
   int pb, l1, l2, sj;
   bit done = 1'b0;

   always #4 clk = ~clk;

   can_bit_timer dut (
      .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .tx_bit(tx_bit),
      .bus_idle(bus_idle), .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1),
      .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw), .sample_stb(sample_stb),
      .rx_bit(rx_bit), .tx_stb(tx_stb)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (sample_stb === 1'b1) last_samp = cyc;
      if (sample_stb === 1'b1 && tx_stb === 1'b1) overlaps++;
   end

   always @(posedge clk) begin
      if (!done && cyc >= 190000) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual %0d cycles expected fewer than %0d", cyc, 190000);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_tx(output int t);
      forever begin
         @(negedge clk);
         if (tx_stb === 1'b1) break;
      end
      t = cyc;
   endtask

   task automatic pulse_low(input int d);
      repeat (d) @(negedge clk);
      rx_raw = 1'b0;
      @(negedge clk);
      rx_raw = 1'b1;
   endtask

   // expected sample and bit-end offsets for one resync edge seen in cycle f
   task automatic model(input int f, input bit drive, output int es, output int et,
                        output string tag);
      int q, ext, e2, c;
      q = f / pb; ext = 0; e2 = l2;
      if (!drive)       tag = "R7";
      else if (q == 0)  tag = "R8";
      else if (q <= l1) begin
         tag = "R5";
         ext = (q < sj) ? q : sj;
      end else begin
         tag = "R6";
         c  = q - 1 - l1;
         e2 = ((l2 - sj) > (c + 1)) ? (l2 - sj) : (c + 1);
      end
      es = pb * (1 + l1 + ext);
      et = pb * (1 + l1 + ext + e2);
   endtask

   task automatic set_cfg(input int b, input int t1, input int t2, input int s);
      int t;
      cfg_brp = 6'(b); cfg_tseg1 = 4'(t1); cfg_tseg2 = 3'(t2); cfg_sjw = 2'(s);
      pb = b + 1; l1 = t1 + 1; l2 = t2 + 1; sj = s + 1;
      wait_tx(t); wait_tx(t);
   endtask

   task automatic free_run;
      int t0, t1, ns, ts;
      ns = 0; ts = -1;
      wait_tx(t0);
      forever begin
         @(negedge clk);
         if (sample_stb === 1'b1) begin ns++; ts = cyc; end
         if (tx_stb === 1'b1) break;
      end
      t1 = cyc;
      chk("R2 nominal bit length", t1 - t0, pb * (l1 + l2 + 1));
      chk("R3 sample point offset", ts - t0, pb * (l1 + 1));
      chk("R3 samples per bit", ns, 1);
   endtask

   task automatic level_test;
      int t0;
      tx_bit = 1'b0;
      wait_tx(t0);
      rx_raw = 1'b0;
      forever begin @(negedge clk); if (sample_stb === 1'b1) break; end
      chk("R3 sampled dominant", int'(rx_bit), 0);
      rx_raw = 1'b1;
      forever begin @(negedge clk); if (sample_stb === 1'b1) break; end
      chk("R3 sampled recessive", int'(rx_bit), 1);
      tx_bit = 1'b1;
   endtask

   // mode 0: resync allowed, 1: node dominant, 2: bus idle (hard sync)
   task automatic trial(input int mode, input int d);
      int t0, t1, es, et;
      string tag;
      bus_idle = (mode == 2);
      tx_bit   = (mode != 1);
      wait_tx(t0);
      pulse_low(d);
      wait_tx(t1);
      if (mode == 2) begin
         chk("R4 restart latency", t1 - t0, d + 3);
         forever begin @(negedge clk); if (sample_stb === 1'b1) break; end
         chk("R4 sample after restart", cyc - t1, pb * (l1 + 1));
      end else begin
         model(d + 2, mode == 0, es, et, tag);
         chk({tag, " sample offset"}, last_samp - t0, es);
         chk({tag, " bit length"}, t1 - t0, et);
      end
      bus_idle = 1'b0;
      tx_bit   = 1'b1;
   endtask

   int cb[6] = '{0, 1, 2, 0, 3, 1};
   int c1[6] = '{3, 2, 5, 7, 1, 0};
   int c2[6] = '{2, 3, 1, 7, 0, 1};
   int cs[6] = '{1, 0, 3, 3, 0, 2};

   initial begin
      int t0, t1, es, et;
      string tag;
      rst_n = 1'b0; rx_raw = 1'b1; tx_bit = 1'b1; bus_idle = 1'b0;
      cfg_brp = '0; cfg_tseg1 = 4'd3; cfg_tseg2 = 3'd2; cfg_sjw = 2'd1;
      repeat (3) @(negedge clk);
      chk("R1 reset sample_stb", int'(sample_stb), 0);
      chk("R1 reset tx_stb", int'(tx_stb), 0);
      chk("R1 reset rx_bit", int'(rx_bit), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset tx_stb", int'(tx_stb), 0);

      for (int i = 0; i < 6; i++) begin
         set_cfg(cb[i], c1[i], c2[i], cs[i]);
         free_run();
         if (pb * (1 + l1) >= 3) level_test();
         for (int m = 0; m < 3; m++)
            for (int d = 0; d <= pb * (l1 + l2 + 1) - 3; d++)
               trial(m, d);
      end

      // R9: second edge in the same bit is ignored
      set_cfg(0, 3, 2, 1);
      wait_tx(t0);
      rx_raw = 1'b0;
      repeat (2) @(negedge clk);
      rx_raw = 1'b1;
      repeat (1) @(negedge clk);
      rx_raw = 1'b0;
      @(negedge clk);
      rx_raw = 1'b1;
      wait_tx(t1);
      model(2, 1'b1, es, et, tag);
      chk("R9 second edge sample", last_samp - t0, es);
      chk("R9 second edge bit length", t1 - t0, et);

      // R9: no resync in a bit started by hard sync
      bus_idle = 1'b1;
      wait_tx(t0);
      pulse_low(1);
      wait_tx(t1);
      chk("R4 hard sync before R9 check", t1 - t0, 4);
      bus_idle = 1'b0;
      pulse_low(1);
      wait_tx(t0);
      chk("R9 no resync after hard sync sample", last_samp - t1, pb * (l1 + 1));
      chk("R9 no resync after hard sync length", t0 - t1, pb * (l1 + l2 + 1));

      chk("R10 strobe overlap count", overlaps, 0);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule